// File: doc/BRIEF.md
# Paged Address Translation Unit

This block turns a CPU virtual address into a physical address through a table of page descriptors, one 16-bit descriptor for each 4 KB page. The page offset (the low 12 bits) passes through unchanged. The bits above the offset pick a descriptor. That descriptor supplies the physical page number, a write-permission flag and a two-bit page state.

Every access is checked against the descriptor. An absent page raises a not-present fault. A store to a page without write permission raises a write-protect fault. A permitted access produces the translated address and advances the page state in hardware, so software can later see which pages were touched or modified.

Software reads and writes the descriptor table one byte at a time through a small configuration port. Each descriptor takes two consecutive byte addresses, with its upper byte at the even address.

Top module: `pat_xlate_unit`

## Requirements
- R1: For a permitted access, `rsp_paddr` equals the descriptor's page number (bits 9..0, of which the low PPN_W bits are used) shifted left by 12, ORed with the 12 untranslated offset bits of `req_addr`.
- R2: Byte address 2·p of the configuration port holds bits 15..8 of descriptor p, and byte address 2·p+1 holds bits 7..0. `cfg_rdata` shows the addressed byte one clock after `cfg_re`.
- R3: Descriptor bits 12..10 read back as written but change neither the translation nor the fault decision.
- R4: An access to a page whose state (bits 14:13) is 00 gives `rsp_fault`=1 with `rsp_code`=01 and `rsp_paddr`=0, and leaves the descriptor unchanged.
- R5: A store to a present page whose write-permission bit (bit 15) is 0 gives `rsp_fault`=1 with `rsp_code`=10, and leaves the state bits unchanged.
- R6: A permitted load moves state 01 to 10 and leaves states 10 and 11 unchanged.
- R7: A permitted store moves state 01 or 10 to 11.
- R8: The descriptor is written back on the same clock edge that registers the response, so a request issued in the very next cycle sees the updated state.
- R9: When a configuration byte write and a hardware state update target the same descriptor in the same cycle, the configuration write wins and the state update is dropped.
- R10: Each request with `req_valid` produces exactly one single-cycle `rsp_valid` pulse on the next clock. A fault-free response carries `rsp_code`=00 and `rsp_fault`=0.
- R11: After reset every descriptor reads zero (all pages absent) and `rsp_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Translation request strobe |
| req_write | input | 1 | Request is a store |
| req_addr | input | IDX_W+12 | Virtual address |
| rsp_valid | output | 1 | Response pulse, one clock after the request |
| rsp_fault | output | 1 | Request was refused |
| rsp_code | output | 2 | 00 ok, 01 not present, 10 write protected |
| rsp_paddr | output | PPN_W+12 | Translated physical address |
| cfg_we | input | 1 | Descriptor byte write |
| cfg_re | input | 1 | Descriptor byte read |
| cfg_addr | input | IDX_W+1 | Descriptor byte address |
| cfg_wdata | input | 8 | Byte to write |
| cfg_rdata | output | 8 | Byte read, valid one clock after cfg_re |

## Verification
The bench builds the unit with IDX_W=6 and PPN_W=10: a 64-entry table with full-width page numbers. The whole table, including the top entry, is then reachable in a few hundred cycles, and every page number bit still shows up in the physical address. The all-ones page number and the spare descriptor bits are exercised, as are back-to-back requests to one page and a configuration write colliding with a state update.

// File: rtl/pat_pkg.sv
package pat_pkg;

    localparam int ENTRY_W  = 16;
    localparam int WPERM_B  = 15;
    localparam int STATE_HI = 14;
    localparam int STATE_LO = 13;
    localparam int PPN_MAXW = 10;

    typedef logic [ENTRY_W-1:0] map_entry_t;

    typedef enum logic [1:0] {
        PG_ABSENT = 2'b00,
        PG_FRESH  = 2'b01,
        PG_READ   = 2'b10,
        PG_DIRTY  = 2'b11
    } pstate_e;

    typedef enum logic [1:0] {
        FLT_NONE   = 2'b00,
        FLT_ABSENT = 2'b01,
        FLT_RDONLY = 2'b10
    } fault_e;

endpackage

// File: rtl/pat_perm_check.sv
module pat_perm_check
    import pat_pkg::*;
(
    input  map_entry_t entry,
    input  logic       is_write,
    output fault_e     fault,
    output map_entry_t entry_nxt,
    output logic       changed
);
    pstate_e st;
    logic    wperm;

    always_comb begin
        st        = pstate_e'(entry[STATE_HI:STATE_LO]);
        wperm     = entry[WPERM_B];
        fault     = FLT_NONE;
        entry_nxt = entry;
        if (st == PG_ABSENT) begin
            fault = FLT_ABSENT;
        end else if (is_write && !wperm) begin
            fault = FLT_RDONLY;
        end else if (is_write) begin
            entry_nxt[STATE_HI:STATE_LO] = PG_DIRTY;
        end else if (st == PG_FRESH) begin
            entry_nxt[STATE_HI:STATE_LO] = PG_READ;
        end
        changed = (entry_nxt != entry);
    end
endmodule

// File: rtl/pat_map_store.sv
module pat_map_store
    import pat_pkg::*;
#(
    parameter int IDX_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IDX_W-1:0] lk_idx,
    output map_entry_t       lk_entry,
    input  logic             upd_en,
    input  logic [IDX_W-1:0] upd_idx,
    input  map_entry_t       upd_entry,
    input  logic             cfg_we,
    input  logic             cfg_re,
    input  logic [IDX_W:0]   cfg_addr,
    input  logic [7:0]       cfg_wdata,
    output logic [7:0]       cfg_rdata
);
    localparam int NUM = 1 << IDX_W;

    typedef struct packed {
        map_entry_t [NUM-1:0] map;
        logic [7:0]           rdata;
    } store_t;

    store_t           st_d, st_q;
    logic [IDX_W-1:0] cfg_idx;
    logic             cfg_lo;
    logic             clash;

    assign cfg_idx  = cfg_addr[IDX_W:1];
    assign cfg_lo   = cfg_addr[0];
    assign clash    = cfg_we && upd_en && (cfg_idx == upd_idx);
    assign lk_entry = st_q.map[lk_idx];
    assign cfg_rdata = st_q.rdata;

    always_comb begin
        st_d = st_q;
        if (upd_en && !clash) begin
            st_d.map[upd_idx] = upd_entry;
        end
        if (cfg_we) begin
            if (cfg_lo) st_d.map[cfg_idx][7:0]  = cfg_wdata;
            else        st_d.map[cfg_idx][15:8] = cfg_wdata;
        end
        if (cfg_re) begin
            st_d.rdata = cfg_lo ? st_q.map[cfg_idx][7:0] : st_q.map[cfg_idx][15:8];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    AST_CFG_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        clash |=> (($past(cfg_lo) ? st_q.map[$past(cfg_idx)][7:0]
                                  : st_q.map[$past(cfg_idx)][15:8]) == $past(cfg_wdata))
                  && (($past(cfg_lo) ? st_q.map[$past(cfg_idx)][15:8]
                                     : st_q.map[$past(cfg_idx)][7:0])
                      == ($past(cfg_lo) ? $past(st_q.map[cfg_idx][15:8])
                                        : $past(st_q.map[cfg_idx][7:0]))))
        else $error("cfg write lost to state update"); // R9

    AST_READ_LAT: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_re && !cfg_we) |=> cfg_rdata == ($past(cfg_lo) ? $past(st_q.map[cfg_idx][7:0])
                                                            : $past(st_q.map[cfg_idx][15:8])))
        else $error("cfg read byte wrong"); // R2
endmodule

// File: rtl/pat_xlate_unit.sv
module pat_xlate_unit
    import pat_pkg::*;
#(
    parameter int IDX_W = 10,
    parameter int OFF_W = 12,
    parameter int PPN_W = 10,
    localparam int VA_W = IDX_W + OFF_W,
    localparam int PA_W = PPN_W + OFF_W
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            req_valid,
    input  logic            req_write,
    input  logic [VA_W-1:0] req_addr,
    output logic            rsp_valid,
    output logic            rsp_fault,
    output logic [1:0]      rsp_code,
    output logic [PA_W-1:0] rsp_paddr,
    input  logic            cfg_we,
    input  logic            cfg_re,
    input  logic [IDX_W:0]  cfg_addr,
    input  logic [7:0]      cfg_wdata,
    output logic [7:0]      cfg_rdata
);
    typedef struct packed {
        logic            valid;
        logic            fault;
        fault_e          code;
        logic [PA_W-1:0] paddr;
    } rsp_t;

    rsp_t             rsp_d, rsp_q;
    logic [IDX_W-1:0] lk_idx;
    map_entry_t       lk_entry;
    map_entry_t       entry_nxt;
    fault_e           chk_fault;
    logic             chk_changed;
    logic             upd_en;
    logic [PPN_W-1:0] ppn;

    assign lk_idx = req_addr[VA_W-1:OFF_W];

    generate
        if (PPN_W <= PPN_MAXW) begin : g_ppn_ok
            assign ppn = lk_entry[PPN_W-1:0];
        end else begin : g_ppn_pad
            assign ppn = {{(PPN_W-PPN_MAXW){1'b0}}, lk_entry[PPN_MAXW-1:0]};
        end
    endgenerate

    pat_map_store #(.IDX_W(IDX_W)) u_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .lk_idx    (lk_idx),
        .lk_entry  (lk_entry),
        .upd_en    (upd_en),
        .upd_idx   (lk_idx),
        .upd_entry (entry_nxt),
        .cfg_we    (cfg_we),
        .cfg_re    (cfg_re),
        .cfg_addr  (cfg_addr),
        .cfg_wdata (cfg_wdata),
        .cfg_rdata (cfg_rdata)
    );

    pat_perm_check u_check (
        .entry     (lk_entry),
        .is_write  (req_write),
        .fault     (chk_fault),
        .entry_nxt (entry_nxt),
        .changed   (chk_changed)
    );

    always_comb begin
        upd_en      = req_valid && chk_changed;
        rsp_d       = '0;
        rsp_d.valid = req_valid;
        if (req_valid) begin
            rsp_d.code  = chk_fault;
            rsp_d.fault = (chk_fault != FLT_NONE);
            if (chk_fault == FLT_NONE) begin
                rsp_d.paddr = {ppn, req_addr[OFF_W-1:0]};
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) rsp_q <= '0;
        else        rsp_q <= rsp_d;
    end

    assign rsp_valid = rsp_q.valid;
    assign rsp_fault = rsp_q.fault;
    assign rsp_code  = rsp_q.code;
    assign rsp_paddr = rsp_q.paddr;

    AST_RSP_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid) else $error("missing response"); // R10
    AST_RSP_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !rsp_valid) else $error("spurious response"); // R10
    AST_OFFSET_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && lk_entry[STATE_HI:STATE_LO] != 2'b00 && !(req_write && !lk_entry[WPERM_B]))
        |=> !rsp_fault && rsp_paddr[OFF_W-1:0] == $past(req_addr[OFF_W-1:0]))
        else $error("offset not passed through"); // R1
    AST_ABSENT_FAULT: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && lk_entry[STATE_HI:STATE_LO] == 2'b00)
        |=> rsp_fault && rsp_code == 2'b01 && rsp_paddr == '0)
        else $error("absent page not faulted"); // R4
    AST_RDONLY_FAULT: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_write && lk_entry[STATE_HI:STATE_LO] != 2'b00 && !lk_entry[WPERM_B])
        |=> rsp_fault && rsp_code == 2'b10)
        else $error("protected page not faulted"); // R5
endmodule

// File: tb/pat_xlate_unit_test.sv
module pat_xlate_unit_test;
    localparam int IDX_W = 6;
    localparam int OFF_W = 12;
    localparam int PPN_W = 10;
    localparam int VA_W  = IDX_W + OFF_W;
    localparam int PA_W  = PPN_W + OFF_W;
    localparam int NUM   = 1 << IDX_W;

    typedef struct packed {
        logic            fault;
        logic [1:0]      code;
        logic [PA_W-1:0] paddr;
    } exp_t;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            req_valid = 1'b0;
    logic            req_write = 1'b0;
    logic [VA_W-1:0] req_addr = '0;
    logic            rsp_valid, rsp_fault;
    logic [1:0]      rsp_code;
    logic [PA_W-1:0] rsp_paddr;
    logic            cfg_we = 1'b0;
    logic            cfg_re = 1'b0;
    logic [IDX_W:0]  cfg_addr = '0;
    logic [7:0]      cfg_wdata = '0;
    logic [7:0]      cfg_rdata;

    int    n_tests = 0;
    int    n_fail  = 0;
    logic [15:0] shadow [NUM];
    exp_t  expq[$];
    string tagq[$];

    always #2 clk = ~clk;

    pat_xlate_unit #(.IDX_W(IDX_W), .OFF_W(OFF_W), .PPN_W(PPN_W)) uut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .rsp_valid(rsp_valid), .rsp_fault(rsp_fault),
        .rsp_code(rsp_code), .rsp_paddr(rsp_paddr), .cfg_we(cfg_we), .cfg_re(cfg_re),
        .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata)
    );

    task automatic summary();
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    endtask

    task automatic check(input bit ok, input string tag, input longint act, input longint exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Reference model taken from the requirements
    task automatic model(input int pg, input bit wr, input int off,
                         output exp_t e, output logic [15:0] nxt);
        logic [15:0] ent;
        ent = shadow[pg];
        nxt = ent;
        e   = '0;
        if (ent[14:13] == 2'b00) begin
            e.fault = 1'b1; e.code = 2'b01;                     // R4
        end else if (wr && !ent[15]) begin
            e.fault = 1'b1; e.code = 2'b10;                     // R5
        end else begin
            e.paddr = {ent[PPN_W-1:0], off[OFF_W-1:0]};         // R1
            if (wr) nxt[14:13] = 2'b11;                         // R7
            else if (ent[14:13] == 2'b01) nxt[14:13] = 2'b10;   // R6
        end
    endtask

    task automatic send_req(input int pg, input int off, input bit wr, input string tag);
        exp_t e;
        logic [15:0] nxt;
        model(pg, wr, off, e, nxt);
        shadow[pg] = nxt;
        expq.push_back(e);
        tagq.push_back(tag);
        req_valid = 1'b1;
        req_write = wr;
        req_addr  = {pg[IDX_W-1:0], off[OFF_W-1:0]};
        @(negedge clk);
    endtask

    // request and colliding configuration byte write in one cycle
    task automatic send_req_cfg(input int pg, input int off, input bit wr,
                                input int baddr, input logic [7:0] d, input string tag);
        exp_t e;
        logic [15:0] nxt;
        model(pg, wr, off, e, nxt);
        if ((baddr >> 1) != pg) shadow[pg] = nxt;               // R9: update dropped on clash
        if (baddr[0]) shadow[baddr >> 1][7:0]  = d;
        else          shadow[baddr >> 1][15:8] = d;
        expq.push_back(e);
        tagq.push_back(tag);
        req_valid = 1'b1; req_write = wr;
        req_addr  = {pg[IDX_W-1:0], off[OFF_W-1:0]};
        cfg_we = 1'b1; cfg_addr = baddr[IDX_W:0]; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic go_idle();
        req_valid = 1'b0;
        req_write = 1'b0;
        @(negedge clk);
    endtask

    task automatic cfg_write(input int baddr, input logic [7:0] d);
        if (baddr[0]) shadow[baddr >> 1][7:0]  = d;
        else          shadow[baddr >> 1][15:8] = d;
        cfg_we = 1'b1; cfg_addr = baddr[IDX_W:0]; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic put_entry(input int pg, input logic [15:0] v);
        cfg_write(2*pg, v[15:8]);
        cfg_write(2*pg + 1, v[7:0]);
    endtask

    task automatic cfg_read_chk(input int baddr, input logic [7:0] exp, input string tag);
        cfg_re = 1'b1; cfg_addr = baddr[IDX_W:0];
        @(negedge clk);
        cfg_re = 1'b0;
        check(cfg_rdata == exp, tag, cfg_rdata, exp);
    endtask

    task automatic entry_chk(input int pg, input string tag);
        cfg_read_chk(2*pg,     shadow[pg][15:8], tag);
        cfg_read_chk(2*pg + 1, shadow[pg][7:0],  tag);
    endtask

    // Monitor: pops the scoreboard on every response pulse
    always @(negedge clk) begin
        if (rst_n && rsp_valid) begin
            if (expq.size() == 0) begin
                check(1'b0, "R10 unexpected rsp_valid", 1, 0);
            end else begin
                exp_t  e;
                string t;
                e = expq.pop_front();
                t = tagq.pop_front();
                check({rsp_fault, rsp_code, rsp_paddr} == e, t,
                      {rsp_fault, rsp_code, rsp_paddr}, e);
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_tests++; n_fail++;
        $display("FAIL watchdog expired actual=running expected=done");
        summary();
    end

    initial begin
        for (int i = 0; i < NUM; i++) shadow[i] = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        check(rsp_valid == 1'b0, "R11 rsp_valid after reset", rsp_valid, 0);
        entry_chk(0, "R11 entry 0 zero");
        entry_chk(5, "R11 entry 5 zero");
        entry_chk(NUM-1, "R11 top entry zero");

        send_req(3, 'h123, 1'b0, "R4 absent read");
        send_req(3, 'h124, 1'b1, "R4 absent write");
        go_idle();
        entry_chk(3, "R4 entry untouched");

        put_entry(3, 16'h2155);                       // state 01, read only
        entry_chk(3, "R2 byte layout");
        send_req(3, 'hABC, 1'b0, "R1 translate read");
        go_idle();
        entry_chk(3, "R6 fresh to read");
        send_req(3, 'h001, 1'b0, "R1 second read");
        go_idle();
        entry_chk(3, "R6 read state stays");
        send_req(3, 'h002, 1'b1, "R5 write protect");
        go_idle();
        entry_chk(3, "R5 state unchanged");

        put_entry(7, 16'hBFFF);                       // WE, 01, spare 111, ppn 3FF
        send_req(7, 'hFFF, 1'b1, "R3 spare bits ignored, top ppn");
        go_idle();
        entry_chk(7, "R7 fresh to dirty");

        put_entry(NUM-1, 16'hA000);
        send_req(NUM-1, 'h010, 1'b0, "R8 read then");
        send_req(NUM-1, 'h020, 1'b1, "R8 write back to back");
        send_req(NUM-1, 'h030, 1'b0, "R8 read after dirty");
        go_idle();
        entry_chk(NUM-1, "R8 dirty after back to back");
        check(rsp_valid == 1'b0, "R10 pulse ends", rsp_valid, 0);

        put_entry(12, 16'hA0AA);
        send_req_cfg(12, 'h777, 1'b0, 2*12, 8'hA0, "R9 rsp during clash");
        go_idle();
        entry_chk(12, "R9 cfg write wins");
        send_req_cfg(12, 'h778, 1'b1, 2*12+1, 8'h55, "R9 rsp during low clash");
        go_idle();
        entry_chk(12, "R9 low byte clash");

        for (int pg = 16; pg < 48; pg++) begin
            logic [15:0] v;
            v = {pg[0] ? 1'b1 : 1'b0, pg[2:1], pg[5:3], 10'((pg * 13 + 7) % 1024)};
            put_entry(pg, v);
        end
        for (int k = 0; k < 96; k++) begin
            send_req(16 + ($urandom % 32), $urandom % 4096, $urandom % 2, "R10 sweep response");
        end
        go_idle();
        for (int pg = 16; pg < 48; pg++) entry_chk(pg, "R7 sweep entry state");

        repeat (3) @(negedge clk);
        check(expq.size() == 0, "R10 all responses seen", expq.size(), 0);
        summary();
    end
endmodule